// File: doc/BRIEF.md
# Multiplierless 16-QAM Interference Cancellation Unit

This block serves one tree level of a breadth-first sphere detector. For each of four tree nodes at once, it takes away from the level's zero-forcing value the interference of the symbols already decided above that level. Every node follows its own path through the tree, so each node has its own decided symbols. All nodes share the zero-forcing value and the row of the upper-triangular channel matrix. The result for each node is b = y − Σ R_j·s_j in complex arithmetic.

The block has no multipliers. A 16-QAM symbol component is always one of ±1 or ±3, so each real product is one sign-adjusted copy of a matrix entry, or that copy plus a copy shifted left by one bit. The real and imaginary results each have their own carry-save compressor tree, and a single ripple-carry adder resolves each tree. A slot-enable mask says how many upper symbols apply at the current level. A registered output stage gives one cycle of latency behind a valid strobe.

Top module: `qam_ic_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R2: When `in_valid` is high, the next cycle's real output of each node equals y_re − Σ over enabled slots of (Rre·sre − Rim·sim), exactly.
- R3: When `in_valid` is high, the next cycle's imaginary output of each node equals y_im − Σ over enabled slots of (Rre·sim + Rim·sre), exactly.
- R4: A 2-bit symbol component code maps as 00 = −3, 01 = −1, 10 = +1 and 11 = +3.
- R5: A slot whose `sym_en` bit is 0 contributes nothing, whatever its matrix entries and codes are.
- R6: With `sym_en` all zero, every node outputs the zero-forcing value, sign-extended.
- R7: Outputs are exact for all 12-bit two's-complement inputs, including full-scale extremes. Their magnitude never exceeds 2^11·(1+6·NSYM).
- R8: Each node uses only its own symbol codes. Nodes given identical codes produce identical outputs.
- R9: While `in_valid` is low, all outputs hold their previous values.
- R10: During reset, `out_valid` and all outputs are zero.
- Field layout: slot k occupies bits [k·IN_W +: IN_W] of the R buses. The code of node n, slot k, occupies bits [(n·NSYM+k)·2 +: 2] of the code buses. The output of node n occupies bits [n·OUT_W +: OUT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input data valid strobe |
| y_re | input | IN_W | Zero-forcing value, real part |
| y_im | input | IN_W | Zero-forcing value, imaginary part |
| r_re | input | NSYM·IN_W | Off-diagonal row entries, real parts |
| r_im | input | NSYM·IN_W | Off-diagonal row entries, imaginary parts |
| sym_en | input | NSYM | Slot enable mask for the current level |
| s_re_code | input | NODES·NSYM·2 | Decided symbol real-component codes |
| s_im_code | input | NODES·NSYM·2 | Decided symbol imaginary-component codes |
| out_valid | output | 1 | Output valid strobe |
| b_re | output | NODES·OUT_W | Cancelled values, real parts |
| b_im | output | NODES·OUT_W | Cancelled values, imaginary parts |

## Verification
On every cycle, the assertions check the following: the one-cycle valid delay, holding while idle, pass-through of the zero-forcing value when no slot is enabled, the output magnitude bound, and equal outputs for nodes fed the same codes. The exact arithmetic has to come from the bench's scenarios. These include the sign and code mapping of every product, the different sign rules of the real and imaginary sums, the masking of disabled slots with non-zero data, and the full-scale corners. In those scenarios a behavioural integer model predicts every output on every clock.

// File: rtl/qam_ic_pkg.sv
package qam_ic_pkg;

    typedef enum logic [1:0] {
        SYM_M3 = 2'b00,
        SYM_M1 = 2'b01,
        SYM_P1 = 2'b10,
        SYM_P3 = 2'b11
    } sym_code_e;

    // number of 3:2 compression levels needed to bring n operands down to two
    function automatic int csa_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 2) begin
            c = (c / 3) * 2 + (c % 3);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/icu_prod_terms.sv
module icu_prod_terms #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 18
) (
    input  logic [IN_W-1:0]  coef,
    input  logic [1:0]       code,
    input  logic             en,
    input  logic             flip,
    output logic [OUT_W-1:0] op_single,
    output logic [OUT_W-1:0] op_double,
    output logic [1:0]       inv_cnt
);
    import qam_ic_pkg::*;

    logic [OUT_W-1:0] ext_x1;
    logic [OUT_W-1:0] ext_x2;
    logic             add_pos;
    logic             mag3;

    always_comb begin
        ext_x1  = {{(OUT_W-IN_W){coef[IN_W-1]}}, coef};
        ext_x2  = {ext_x1[OUT_W-2:0], 1'b0};
        // product is positive when the code's upper bit is set; flip inverts the contribution
        add_pos = code[1] ^ flip;
        mag3    = (code == SYM_P3) || (code == SYM_M3);

        op_single = '0;
        op_double = '0;
        inv_cnt   = 2'd0;
        if (en) begin
            op_single = add_pos ? ext_x1 : ~ext_x1;
            if (mag3) begin
                op_double = add_pos ? ext_x2 : ~ext_x2;
            end
            if (!add_pos) begin
                inv_cnt = mag3 ? 2'd2 : 2'd1;
            end
        end
    end

endmodule

// File: rtl/icu_csa_tree.sv
module icu_csa_tree #(
    parameter int N_OPS = 14,
    parameter int OUT_W = 18
) (
    input  logic [OUT_W-1:0] ops [N_OPS],
    output logic [OUT_W-1:0] total
);
    import qam_ic_pkg::*;

    localparam int NLVL = csa_levels(N_OPS);
    localparam int IW   = $clog2(N_OPS + 1);

    logic [OUT_W-1:0] vec_a;
    logic [OUT_W-1:0] vec_b;

    // Wallace-style reduction: every level compresses each full triple to sum and shifted carry
    always_comb begin
        logic [OUT_W-1:0] work_d [N_OPS];
        logic [OUT_W-1:0] next_d [N_OPS];
        logic [OUT_W-1:0] maj;
        int cnt;
        int nxt;
        int idx;
        work_d = ops;
        cnt    = N_OPS;
        for (int l = 0; l < NLVL; l++) begin
            for (int z = 0; z < N_OPS; z++) begin
                next_d[z] = '0;
            end
            nxt = 0;
            for (int g = 0; g < N_OPS / 3; g++) begin
                if (3 * g + 2 < cnt) begin
                    maj = (work_d[3*g] & work_d[3*g+1]) |
                          (work_d[3*g] & work_d[3*g+2]) |
                          (work_d[3*g+1] & work_d[3*g+2]);
                    next_d[IW'(nxt)]     = work_d[3*g] ^ work_d[3*g+1] ^ work_d[3*g+2];
                    next_d[IW'(nxt + 1)] = {maj[OUT_W-2:0], 1'b0};
                    nxt = nxt + 2;
                end
            end
            for (int r = 0; r < 3; r++) begin
                idx = (cnt / 3) * 3 + r;
                if (idx < cnt) begin
                    next_d[IW'(nxt)] = work_d[IW'(idx)];
                    nxt = nxt + 1;
                end
            end
            work_d = next_d;
            cnt    = nxt;
        end
        vec_a = work_d[0];
        vec_b = work_d[1];
    end

    // single carry-propagate stage
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < OUT_W; i++) begin
            total[i] = vec_a[i] ^ vec_b[i] ^ cy;
            cy       = (vec_a[i] & vec_b[i]) | (vec_a[i] & cy) | (vec_b[i] & cy);
        end
    end

endmodule

// File: rtl/icu_node.sv
module icu_node #(
    parameter int IN_W  = 12,
    parameter int NSYM  = 3,
    parameter int OUT_W = 18
) (
    input  logic [IN_W-1:0]      y_re,
    input  logic [IN_W-1:0]      y_im,
    input  logic [NSYM*IN_W-1:0] r_re,
    input  logic [NSYM*IN_W-1:0] r_im,
    input  logic [NSYM-1:0]      sym_en,
    input  logic [NSYM*2-1:0]    s_re_code,
    input  logic [NSYM*2-1:0]    s_im_code,
    output logic [OUT_W-1:0]     b_re,
    output logic [OUT_W-1:0]     b_im
);
    // operands per part: y, four terms per slot, one inversion-correction word
    localparam int N_OPS = 4 * NSYM + 2;

    logic [OUT_W-1:0] ops_re [N_OPS];
    logic [OUT_W-1:0] ops_im [N_OPS];
    logic [1:0]       inv_re [2*NSYM];
    logic [1:0]       inv_im [2*NSYM];

    assign ops_re[0] = {{(OUT_W-IN_W){y_re[IN_W-1]}}, y_re};
    assign ops_im[0] = {{(OUT_W-IN_W){y_im[IN_W-1]}}, y_im};

    for (genvar k = 0; k < NSYM; k++) begin : g_slot
        // real part: -Rre*sre + Rim*sim
        icu_prod_terms #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rr_sr (
            .coef(r_re[k*IN_W +: IN_W]), .code(s_re_code[k*2 +: 2]), .en(sym_en[k]), .flip(1'b1),
            .op_single(ops_re[1+4*k]), .op_double(ops_re[2+4*k]), .inv_cnt(inv_re[2*k]));
        icu_prod_terms #(.IN_W(IN_W), .OUT_W(OUT_W)) u_ri_si (
            .coef(r_im[k*IN_W +: IN_W]), .code(s_im_code[k*2 +: 2]), .en(sym_en[k]), .flip(1'b0),
            .op_single(ops_re[3+4*k]), .op_double(ops_re[4+4*k]), .inv_cnt(inv_re[2*k+1]));
        // imaginary part: -Rre*sim - Rim*sre
        icu_prod_terms #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rr_si (
            .coef(r_re[k*IN_W +: IN_W]), .code(s_im_code[k*2 +: 2]), .en(sym_en[k]), .flip(1'b1),
            .op_single(ops_im[1+4*k]), .op_double(ops_im[2+4*k]), .inv_cnt(inv_im[2*k]));
        icu_prod_terms #(.IN_W(IN_W), .OUT_W(OUT_W)) u_ri_sr (
            .coef(r_im[k*IN_W +: IN_W]), .code(s_re_code[k*2 +: 2]), .en(sym_en[k]), .flip(1'b1),
            .op_single(ops_im[3+4*k]), .op_double(ops_im[4+4*k]), .inv_cnt(inv_im[2*k+1]));
    end

    // the +1 of every one's-complement negation, gathered into one operand
    always_comb begin
        logic [OUT_W-1:0] corr_re;
        logic [OUT_W-1:0] corr_im;
        corr_re = '0;
        corr_im = '0;
        for (int t = 0; t < 2 * NSYM; t++) begin
            corr_re = corr_re + OUT_W'(inv_re[t]);
            corr_im = corr_im + OUT_W'(inv_im[t]);
        end
        ops_re[N_OPS-1] = corr_re;
        ops_im[N_OPS-1] = corr_im;
    end

    icu_csa_tree #(.N_OPS(N_OPS), .OUT_W(OUT_W)) u_tree_re (.ops(ops_re), .total(b_re));
    icu_csa_tree #(.N_OPS(N_OPS), .OUT_W(OUT_W)) u_tree_im (.ops(ops_im), .total(b_im));

endmodule

// File: rtl/qam_ic_unit.sv
module qam_ic_unit #(
    parameter int IN_W  = 12,
    parameter int NSYM  = 3,
    parameter int NODES = 4,
    parameter int OUT_W = IN_W + $clog2(6 * NSYM + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         y_re,
    input  logic [IN_W-1:0]         y_im,
    input  logic [NSYM*IN_W-1:0]    r_re,
    input  logic [NSYM*IN_W-1:0]    r_im,
    input  logic [NSYM-1:0]         sym_en,
    input  logic [NODES*NSYM*2-1:0] s_re_code,
    input  logic [NODES*NSYM*2-1:0] s_im_code,
    output logic                    out_valid,
    output logic [NODES*OUT_W-1:0]  b_re,
    output logic [NODES*OUT_W-1:0]  b_im
);
    localparam int CW    = NSYM * 2;
    localparam int BOUND = (2 ** (IN_W - 1)) * (1 + 6 * NSYM);

    typedef struct packed {
        logic                   vld;
        logic [NODES*OUT_W-1:0] re;
        logic [NODES*OUT_W-1:0] im;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [NODES*OUT_W-1:0] node_re;
    logic [NODES*OUT_W-1:0] node_im;

    for (genvar n = 0; n < NODES; n++) begin : g_node
        icu_node #(.IN_W(IN_W), .NSYM(NSYM), .OUT_W(OUT_W)) u_node (
            .y_re(y_re), .y_im(y_im), .r_re(r_re), .r_im(r_im), .sym_en(sym_en),
            .s_re_code(s_re_code[n*CW +: CW]), .s_im_code(s_im_code[n*CW +: CW]),
            .b_re(node_re[n*OUT_W +: OUT_W]), .b_im(node_im[n*OUT_W +: OUT_W]));
    end

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = in_valid;
        if (in_valid) begin
            pipe_d.re = node_re;
            pipe_d.im = node_im;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.vld;
    assign b_re      = pipe_q.re;
    assign b_im      = pipe_q.im;

    logic signed [OUT_W-1:0] y_re_ext;
    logic signed [OUT_W-1:0] y_im_ext;
    assign y_re_ext = {{(OUT_W-IN_W){y_re[IN_W-1]}}, y_re};
    assign y_im_ext = {{(OUT_W-IN_W){y_im[IN_W-1]}}, y_im};

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(b_re) && $stable(b_im))); // R9

    AST_Y_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sym_en == '0) |=>
        ($signed(b_re[0 +: OUT_W]) == $past(y_re_ext) && $signed(b_im[0 +: OUT_W]) == $past(y_im_ext))); // R6

    for (genvar n = 0; n < NODES; n++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(b_re[n*OUT_W +: OUT_W]) <= BOUND && $signed(b_re[n*OUT_W +: OUT_W]) >= -BOUND &&
             $signed(b_im[n*OUT_W +: OUT_W]) <= BOUND && $signed(b_im[n*OUT_W +: OUT_W]) >= -BOUND)); // R7
        if (n > 0) begin : g_pair
            AST_NODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && s_re_code[n*CW +: CW] == s_re_code[0 +: CW] &&
                 s_im_code[n*CW +: CW] == s_im_code[0 +: CW]) |=>
                (b_re[n*OUT_W +: OUT_W] == b_re[0 +: OUT_W] && b_im[n*OUT_W +: OUT_W] == b_im[0 +: OUT_W])); // R8
        end
    end

endmodule

// File: tb/qam_ic_unit_bench.sv
module qam_ic_unit_bench;
    localparam int PERIOD = 10;
    localparam int IN_W   = 12;
    localparam int NSYM   = 3;
    localparam int NODES  = 4;
    localparam int OUT_W  = IN_W + $clog2(6 * NSYM + 1) + 1;
    localparam int CW     = NSYM * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] y_re = '0, y_im = '0;
    logic [NSYM*IN_W-1:0] r_re = '0, r_im = '0;
    logic [NSYM-1:0] sym_en = '0;
    logic [NODES*NSYM*2-1:0] s_re_code = '0, s_im_code = '0;
    logic out_valid;
    logic [NODES*OUT_W-1:0] b_re, b_im;

    int checks = 0;
    int bad = 0;
    string tag = "R10";

    int exp_valid = 0;
    int exp_re [NODES];
    int exp_im [NODES];

    always #(PERIOD/2) clk = ~clk;

    qam_ic_unit u_qam_ic_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_re(y_re), .y_im(y_im),
        .r_re(r_re), .r_im(r_im), .sym_en(sym_en), .s_re_code(s_re_code), .s_im_code(s_im_code),
        .out_valid(out_valid), .b_re(b_re), .b_im(b_im));

    // R4 encoding: 00=-3 01=-1 10=+1 11=+3
    function automatic int cval(input logic [1:0] c);
        return 2 * int'(c) - 3;
    endfunction

    function automatic int sx(input logic [IN_W-1:0] v);
        return int'($signed(v));
    endfunction

    // behavioural reference model, one register stage
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 0;
            for (int n = 0; n < NODES; n++) begin
                exp_re[n] <= 0;
                exp_im[n] <= 0;
            end
        end else begin
            exp_valid <= int'(in_valid);
            if (in_valid) begin
                for (int n = 0; n < NODES; n++) begin
                    int ar;
                    int ai;
                    ar = sx(y_re);
                    ai = sx(y_im);
                    for (int k = 0; k < NSYM; k++) begin
                        if (sym_en[k]) begin
                            int rr, ri, sr, si;
                            rr = sx(r_re[k*IN_W +: IN_W]);
                            ri = sx(r_im[k*IN_W +: IN_W]);
                            sr = cval(s_re_code[(n*NSYM+k)*2 +: 2]);
                            si = cval(s_im_code[(n*NSYM+k)*2 +: 2]);
                            ar = ar - (rr * sr - ri * si);
                            ai = ai - (rr * si + ri * sr);
                        end
                    end
                    exp_re[n] <= ar;
                    exp_im[n] <= ai;
                end
            end
        end
    end

    task automatic check_int(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check_int("R1", "out_valid", int'(out_valid), exp_valid);
            for (int n = 0; n < NODES; n++) begin
                check_int(tag, $sformatf("node%0d re", n), int'($signed(b_re[n*OUT_W +: OUT_W])), exp_re[n]);
                check_int(tag, $sformatf("node%0d im", n), int'($signed(b_im[n*OUT_W +: OUT_W])), exp_im[n]);
            end
        end
    end

    task automatic rand_data();
        y_re = IN_W'($urandom);
        y_im = IN_W'($urandom);
        r_re = (NSYM*IN_W)'({$urandom, $urandom});
        r_im = (NSYM*IN_W)'({$urandom, $urandom});
        s_re_code = (NODES*NSYM*2)'($urandom);
        s_im_code = (NODES*NSYM*2)'($urandom);
    endtask

    initial begin
        #(PERIOD * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // R10: reset state, driving activity during reset
        in_valid = 1'b1;
        sym_en = '1;
        rand_data();
        repeat (3) @(negedge clk);
        check_int("R10", "out_valid in reset", int'(out_valid), 0);
        check_int("R10", "b_re in reset", int'(b_re != '0), 0);
        check_int("R10", "b_im in reset", int'(b_im != '0), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: random full-level operation
        tag = "R2 R3";
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = '1;
            rand_data();
        end

        // R4: sweep every code combination on a fixed row
        tag = "R4";
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = 3'b001;
            y_re = 12'sd100;
            y_im = -12'sd50;
            r_re = {12'd0, 12'd0, 12'sd37};
            r_im = {12'd0, 12'd0, -12'sd19};
            for (int n = 0; n < NODES; n++) begin
                s_re_code[(n*NSYM)*2 +: 2] = 2'(c >> 2);
                s_im_code[(n*NSYM)*2 +: 2] = 2'(c + n);
            end
        end

        // R5: partial masks with non-zero data in disabled slots
        tag = "R5";
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = NSYM'(c % 7);
            rand_data();
        end

        // R6: top level, nothing enabled
        tag = "R6";
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = '0;
            rand_data();
        end

        // R7: full-scale corners
        tag = "R7";
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = '1;
            y_re = (c % 2 == 0) ? 12'h7FF : 12'h800;
            y_im = (c % 2 == 0) ? 12'h800 : 12'h7FF;
            r_re = (c < 4) ? {3{12'h800}} : {3{12'h7FF}};
            r_im = (c % 4 < 2) ? {3{12'h800}} : {3{12'h7FF}};
            s_re_code = (c % 3 == 0) ? '1 : '0;
            s_im_code = (c % 3 == 1) ? '1 : '0;
            s_re_code[CW +: CW] = '1;
            s_im_code[CW +: CW] = '0;
        end

        // R8: node 0 and 2 share codes, others differ
        tag = "R8";
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            sym_en = '1;
            rand_data();
            s_re_code[2*CW +: CW] = s_re_code[0 +: CW];
            s_im_code[2*CW +: CW] = s_im_code[0 +: CW];
        end

        // R9 R1: gaps in valid with changing data while idle
        tag = "R9";
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            in_valid = (c % 3 == 0);
            sym_en = '1;
            rand_data();
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule